// File: doc/BRIEF.md
# Serial Divider Programming Interface

This block is the serial loading port of a frequency synthesizer. It takes three slow external signals: a shift clock, a serial data line and a transfer strobe. All three are brought into the system clock domain through two-flop synchronizers. Each rising edge of the synchronized shift clock pushes one data bit into a shift chain. That chain is long enough to hold the larger of the two load formats.

The most recent bit in the chain is a destination flag. A rising edge on the transfer strobe copies the chain into one of two holding-latch groups, chosen by that flag. When the flag is 1, the 14-bit reference divide value is written. When the flag is 0, the 10-bit main divide value and the 7-bit swallow divide value are written together. The latched values drive the divider counters, which are not part of this block. Each group raises a single-cycle update pulse when it is written.

Top module: `divprog_serial`

## Requirements
- R1: After reset, `ref_div_o` is 0x3FFF, `n_div_o` is 0x3FF, `a_div_o` is 0x7F, and both update pulses are low.
- R2: Every rising edge of `sclk_i` shifts the level of `sdata_i` into the chain. The first bit shifted in is the most significant bit of the first field.
- R3: If the last bit shifted before a transfer is 1, the transfer loads `ref_div_o` with the 14 bits shifted just before it, MSB first. `n_div_o` and `a_div_o` do not change.
- R4: If the last bit shifted before a transfer is 0, the 17 bits before it are split as follows. The first 10 bits go to `n_div_o` and the next 7 bits go to `a_div_o`, each MSB first. `ref_div_o` does not change.
- R5: A transfer happens once, on each rising edge of `slatch_i`. While `slatch_i` stays high, further shifting does not change any output.
- R6: When `slatch_i` is low, shifting any number of bits leaves all three latched outputs unchanged.
- R7: Each transfer raises the pulse of the written group (`ref_upd_o` or `an_upd_o`) for exactly one system clock cycle, in the same cycle as the new value appears. The other group's pulse stays low. The two pulses are never high together.
- R8: A load may be longer than its format. Only the most recent bits count, and bits shifted in earlier fall off the end of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| slatch_i | input | 1 | Transfer strobe, normally low (asynchronous) |
| ref_div_o | output | 14 | Latched reference divide value |
| n_div_o | output | 10 | Latched main divide value |
| a_div_o | output | 7 | Latched swallow divide value |
| ref_upd_o | output | 1 | One-cycle pulse when the reference latch is written |
| an_upd_o | output | 1 | One-cycle pulse when the main and swallow latches are written |

## Verification
A table of reference loads and main/swallow loads is applied in an interleaved order. Some patterns have alternating bits and some have walking ones, so a field that is swapped, shifted by one position or reversed in bit order gives a wrong value. Alternating the two destinations shows whether a write leaks into the group that was not selected.

Directed sequences cover the remaining cases:
- shifting a full load while the strobe is low, which must leave the outputs unchanged;
- shifting while the strobe is held high, which must not trigger a second transfer;
- an overlong load, whose extra leading bits must be discarded.

// File: rtl/divprog_pkg.sv
package divprog_pkg;
  localparam int unsigned REF_W_DEF = 14;
  localparam int unsigned N_W_DEF   = 10;
  localparam int unsigned A_W_DEF   = 7;

  typedef enum logic {
    DST_AN  = 1'b0,
    DST_REF = 1'b1
  } dst_e;
endpackage

// File: rtl/divprog_sync.sv
module divprog_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/divprog_shift.sv
module divprog_shift #(
  parameter int unsigned SR_W = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q;

  // newest bit lands at position 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[SR_W-2:0], bit_i};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/divprog_latch.sv
module divprog_latch
  import divprog_pkg::*;
#(
  parameter int unsigned R_W  = REF_W_DEF,
  parameter int unsigned N_W  = N_W_DEF,
  parameter int unsigned A_W  = A_W_DEF,
  parameter int unsigned SR_W = N_W + A_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xfer_i,
  input  logic [SR_W-1:0] sr_i,
  output logic [R_W-1:0]  ref_o,
  output logic [N_W-1:0]  n_o,
  output logic [A_W-1:0]  a_o,
  output logic            ref_upd_o,
  output logic            an_upd_o
);
  localparam int unsigned A_LSB = 1;
  localparam int unsigned N_LSB = A_LSB + A_W;

  dst_e           dst;
  logic [R_W-1:0] r_fld;
  logic [N_W-1:0] n_fld;
  logic [A_W-1:0] a_fld;

  assign dst   = dst_e'(sr_i[0]);
  assign r_fld = sr_i[A_LSB +: R_W];
  assign a_fld = sr_i[A_LSB +: A_W];
  assign n_fld = sr_i[N_LSB +: N_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o     <= '1;
      n_o       <= '1;
      a_o       <= '1;
      ref_upd_o <= 1'b0;
      an_upd_o  <= 1'b0;
    end else begin
      ref_upd_o <= 1'b0;
      an_upd_o  <= 1'b0;
      if (xfer_i) begin
        if (dst == DST_REF) begin
          ref_o     <= r_fld;
          ref_upd_o <= 1'b1;
        end else begin
          n_o      <= n_fld;
          a_o      <= a_fld;
          an_upd_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/divprog_serial.sv
module divprog_serial
  import divprog_pkg::*;
#(
  parameter int unsigned R_W = REF_W_DEF,
  parameter int unsigned N_W = N_W_DEF,
  parameter int unsigned A_W = A_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           slatch_i,
  output logic [R_W-1:0] ref_div_o,
  output logic [N_W-1:0] n_div_o,
  output logic [A_W-1:0] a_div_o,
  output logic           ref_upd_o,
  output logic           an_upd_o
);
  localparam int unsigned AN_BITS = N_W + A_W;
  localparam int unsigned SR_W    = ((R_W > AN_BITS) ? R_W : AN_BITS) + 1;

  logic [2:0]      pins_s;
  logic            sclk_s, sdata_s, slatch_s;
  logic            sclk_d, slatch_d;
  logic            shift, xfer;
  logic [SR_W-1:0] sr;

  divprog_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({slatch_i, sdata_i, sclk_i}),
    .q_o   (pins_s)
  );

  assign {slatch_s, sdata_s, sclk_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      slatch_d <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      slatch_d <= slatch_s;
    end
  end

  assign shift = sclk_s & ~sclk_d;
  assign xfer  = slatch_s & ~slatch_d;

  divprog_shift #(.SR_W(SR_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .bit_i  (sdata_s),
    .sr_o   (sr)
  );

  divprog_latch #(.R_W(R_W), .N_W(N_W), .A_W(A_W), .SR_W(SR_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (xfer),
    .sr_i     (sr),
    .ref_o    (ref_div_o),
    .n_o      (n_div_o),
    .a_o      (a_div_o),
    .ref_upd_o(ref_upd_o),
    .an_upd_o (an_upd_o)
  );
endmodule

// File: rtl/divprog_serial_chk.sv
module divprog_serial_chk #(
  parameter int unsigned R_W = 14,
  parameter int unsigned N_W = 10,
  parameter int unsigned A_W = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [R_W-1:0] ref_div_o,
  input logic [N_W-1:0] n_div_o,
  input logic [A_W-1:0] a_div_o,
  input logic           ref_upd_o,
  input logic           an_upd_o
);
  p_upd_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_upd_o && an_upd_o));

  p_ref_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_upd_o |=> !ref_upd_o);

  p_an_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_upd_o |=> !an_upd_o);

  p_ref_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_div_o) |-> ref_upd_o);

  p_n_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_div_o) |-> an_upd_o);

  p_a_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(a_div_o) |-> an_upd_o);
endmodule

bind divprog_serial divprog_serial_chk #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_div_o(ref_div_o),
  .n_div_o  (n_div_o),
  .a_div_o  (a_div_o),
  .ref_upd_o(ref_upd_o),
  .an_upd_o (an_upd_o)
);

// File: tb/divprog_serial_bench.sv
`timescale 1ns/1ps
module divprog_serial_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0, sdata = 1'b0, slatch = 1'b0;
  logic [13:0] ref_div;
  logic [9:0]  n_div;
  logic [6:0]  a_div;
  logic        ref_upd, an_upd;

  int checks = 0, fails = 0;
  int ref_pulses = 0, an_pulses = 0;
  logic [13:0] exp_r = 14'h3FFF;
  logic [9:0]  exp_n = 10'h3FF;
  logic [6:0]  exp_a = 7'h7F;

  always #4 clk = ~clk;

  divprog_serial u_divprog_serial (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .slatch_i(slatch),
    .ref_div_o(ref_div), .n_div_o(n_div), .a_div_o(a_div),
    .ref_upd_o(ref_upd), .an_upd_o(an_upd)
  );

  // pulse counters count high cycles, so width and count are checked together
  always @(posedge clk) begin
    if (ref_upd) ref_pulses <= ref_pulses + 1;
    if (an_upd)  an_pulses  <= an_pulses + 1;
  end

  localparam int NV = 8;
  localparam logic        V_DST [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [13:0] V_R   [NV] = '{14'h2AAA, 14'h0, 14'h0001, 14'h0, 14'h0, 14'h2000, 14'h0, 14'h1234};
  localparam logic [9:0]  V_N   [NV] = '{10'h0, 10'h155, 10'h0, 10'h200, 10'h001, 10'h0, 10'h3C3, 10'h0};
  localparam logic [6:0]  V_A   [NV] = '{7'h0, 7'h2A, 7'h0, 7'h01, 7'h40, 7'h0, 7'h15, 7'h0};

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;  wait_n(4);
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic shift_ref(input logic [13:0] r);
    for (int i = 13; i >= 0; i--) shift_bit(r[i]);
    shift_bit(1'b1);
  endtask

  task automatic shift_an(input logic [9:0] n, input logic [6:0] a);
    for (int i = 9; i >= 0; i--) shift_bit(n[i]);
    for (int i = 6; i >= 0; i--) shift_bit(a[i]);
    shift_bit(1'b0);
  endtask

  task automatic strobe();
    slatch = 1'b1; wait_n(6);
    slatch = 1'b0; wait_n(6);
  endtask

  task automatic check_all(input string req);
    chk({req, " ref"}, 32'(ref_div), 32'(exp_r));
    chk({req, " n"},   32'(n_div),   32'(exp_n));
    chk({req, " a"},   32'(a_div),   32'(exp_a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rp, ap;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(3);
    // R1 reset values
    check_all("R1");
    chk("R1 ref_upd", 32'(ref_upd), 0);
    chk("R1 an_upd",  32'(an_upd),  0);

    // R2 R3 R4 R7: vector table, interleaved destinations
    for (int v = 0; v < NV; v++) begin
      rp = ref_pulses; ap = an_pulses;
      if (V_DST[v]) begin
        shift_ref(V_R[v]);
        exp_r = V_R[v];
      end else begin
        shift_an(V_N[v], V_A[v]);
        exp_n = V_N[v]; exp_a = V_A[v];
      end
      strobe();
      check_all(V_DST[v] ? "R3 R2" : "R4 R2");
      chk("R7 ref pulse count", 32'(ref_pulses - rp), 32'(V_DST[v] ? 1 : 0));
      chk("R7 an pulse count",  32'(an_pulses - ap),  32'(V_DST[v] ? 0 : 1));
    end

    // R6: shift a full load with strobe low, outputs must hold
    rp = ref_pulses; ap = an_pulses;
    shift_an(10'h0AA, 7'h33);
    check_all("R6 an shifted no strobe");
    shift_ref(14'h0F0F);
    check_all("R6 ref shifted no strobe");
    chk("R6 no pulses", 32'(ref_pulses + an_pulses - rp - ap), 0);
    // strobe now commits the last shifted reference load
    strobe();
    exp_r = 14'h0F0F;
    check_all("R3 after R6");

    // R5: hold strobe high, shift another load, no second transfer
    shift_an(10'h123, 7'h45);
    slatch = 1'b1; wait_n(6);
    exp_n = 10'h123; exp_a = 7'h45;
    check_all("R5 first edge");
    rp = ref_pulses; ap = an_pulses;
    shift_ref(14'h3001);
    check_all("R5 held high");
    chk("R5 no pulse while high", 32'(ref_pulses + an_pulses - rp - ap), 0);
    slatch = 1'b0; wait_n(6);
    check_all("R5 falling edge");

    // R8: overlong load, leading garbage bits fall off
    for (int i = 0; i < 9; i++) shift_bit(1'b1);
    shift_an(10'h011, 7'h22);
    strobe();
    exp_n = 10'h011; exp_a = 7'h22;
    check_all("R8 overlong an");
    for (int i = 0; i < 6; i++) shift_bit(i[0]);
    shift_ref(14'h0155);
    strobe();
    exp_r = 14'h0155;
    check_all("R8 overlong ref");

    // R1: reset mid-run restores all ones
    rst_ni = 1'b0; wait_n(2);
    rst_ni = 1'b1; wait_n(3);
    exp_r = 14'h3FFF; exp_n = 10'h3FF; exp_a = 7'h7F;
    check_all("R1 re-reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule